// File: doc/BRIEF.md
# I2C EEPROM Sequential-Read Master

This block is the startup loader of a larger chip. It owns a private two-wire bus to one serial EEPROM at the fixed 7-bit device address 7'b1010000. On a start pulse it sets the EEPROM's internal pointer to a chosen word address and then streams a given number of bytes out of the device. Each byte appears on `data_o` together with a one-cycle `valid_o` pulse. The block is always the bus master. It never writes to the device, and it knows only this one access pattern.

Both lines are open drain. The block only pulls a line low, through an output-enable signal, or releases it. The board pull-ups make the high level, and the SDA level is read back through `sda_i`. Every bit lasts four quarter periods, and each quarter lasts `QUARTER_CLKS` system clocks. The default suits a 100 kbit/s bus on a 100 MHz clock. SCL is low for the first two quarters of a bit and released for the last two. The master changes SDA in the second quarter, while SCL is low. It samples SDA at the end of the third quarter, while SCL is high.

When the device does not acknowledge one of the address bytes, the transfer ends with a STOP, and `nack_err_o` is raised together with `done_o`.

Top module: `eeprom_seq_reader`

## Requirements
- R1: After reset both line enables (`scl_oe_o`, `sda_oe_o`) are 0, which means released, and `valid_o`, `done_o` and `nack_err_o` are 0.
- R2: A start pulse with a count N ≥ 1 produces this bus sequence: START, the byte 0xA0 (device address followed by the write bit 0), the word-address byte, a repeated START, the byte 0xA1 (read bit 1), N data bytes and a STOP. Every SCL low pulse lasts 2·QUARTER_CLKS clocks, and every SCL high time between two low pulses lasts 2·QUARTER_CLKS clocks.
- R3: SDA changes while SCL is high only to form a START (falling) or a STOP (rising). A successful transfer therefore shows exactly two START conditions and one STOP.
- R4: Each read byte is assembled MSB first from SDA samples taken while SCL is high. It is presented on `data_o` during a single-cycle `valid_o` pulse, and the bytes arrive in consecutive EEPROM address order starting at the word address.
- R5: In the ninth bit of every read byte except the last, the master pulls SDA low (ACK). In the ninth bit of the last byte it leaves SDA released (NACK).
- R6: A successful transfer raises `valid_o` exactly N times, and never in the same cycle as `done_o`.
- R7: If any of the three address bytes is not acknowledged (SDA high in its ninth bit), the master sends no further byte and issues a STOP. `done_o` then pulses with `nack_err_o` = 1. `nack_err_o` stays 1 until the next accepted start.
- R8: `done_o` is a one-cycle pulse, given only after the closing STOP has been placed on the bus. On success `nack_err_o` is 0.
- R9: A start pulse that arrives while a transfer is in progress is ignored. The running transfer keeps its word address and its count.
- R10: A start pulse with N = 0 gives a `done_o` pulse on the next cycle, with `nack_err_o` = 0, no `valid_o` and no bus activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only when idle |
| word_addr_i | input | 8 | First EEPROM word address to read |
| byte_cnt_i | input | CNT_W | Number of bytes to read (0 = no transfer) |
| sda_i | input | 1 | Level sampled on the SDA line |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| data_o | output | 8 | Received byte |
| valid_o | output | 1 | One-cycle strobe for `data_o` |
| done_o | output | 1 | One-cycle end-of-transfer strobe |
| nack_err_o | output | 1 | Address phase was not acknowledged |

## Verification
A behavioural EEPROM on the wired-AND bus checks the transfers for several counts and word addresses, including a single-byte read and an address that wraps past 0xFF. The single-byte read catches a design that sends an ACK before its last byte; the slave would then drive the next bit and hold SDA against the STOP. The slave refuses each of the three address bytes in turn. A design that ignored the refusal would deliver bytes; one that skipped the STOP would leave an unbalanced START/STOP count. Further cases check for extra SDA edges while SCL is high, which would look like spurious START or STOP conditions, for a shortened SCL phase, for a retriggered start that corrupts the running transfer, and for a zero count that still touches the bus.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

    localparam logic [6:0] DEV_ADDR = 7'b1010000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WR,
        ST_RD,
        ST_STOP
    } ctl_state_e;

    typedef enum logic [1:0] {
        SYM_NONE,
        SYM_START,
        SYM_BIT,
        SYM_STOP
    } sym_e;

endpackage

// File: rtl/eeprom_phase_gen.sv
module eeprom_phase_gen #(
    parameter int unsigned QUARTER_CLKS = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    output logic       tick_o,
    output logic [1:0] phase_o
);
    localparam int unsigned CW = (QUARTER_CLKS > 1) ? $clog2(QUARTER_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(QUARTER_CLKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    ph;
    } pg_t;

    pg_t pg_d, pg_q;

    assign tick_o  = run_i && (pg_q.cnt == LAST);
    assign phase_o = pg_q.ph;

    always_comb begin
        pg_d = pg_q;
        if (!run_i) begin
            pg_d = '0;
        end else if (tick_o) begin
            pg_d.cnt = '0;
            pg_d.ph  = pg_q.ph + 2'd1;
        end else begin
            pg_d.cnt = pg_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end
endmodule

// File: rtl/eeprom_line_drv.sv
module eeprom_line_drv
    import eeprom_rd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sym_e       sym_i,
    input  logic [1:0] phase_i,
    input  logic       rls_i,
    input  logic       restart_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } lines_t;

    lines_t ln_d, ln_q;

    always_comb begin
        ln_d = ln_q;
        unique case (sym_i)
            SYM_START: begin
                ln_d.scl = restart_i && (phase_i < 2'd2);
                if (phase_i != 2'd0) ln_d.sda = (phase_i == 2'd3);
            end
            SYM_BIT: begin
                ln_d.scl = (phase_i < 2'd2);
                if (phase_i != 2'd0) ln_d.sda = !rls_i;
            end
            SYM_STOP: begin
                ln_d.scl = (phase_i < 2'd2);
                if (phase_i != 2'd0) ln_d.sda = (phase_i != 2'd3);
            end
            default: ln_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign scl_oe_o = ln_q.scl;
    assign sda_oe_o = ln_q.sda;
endmodule

// File: rtl/eeprom_seq_reader.sv
module eeprom_seq_reader
    import eeprom_rd_pkg::*;
#(
    parameter int unsigned QUARTER_CLKS = 250,
    parameter int unsigned CNT_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       word_addr_i,
    input  logic [CNT_W-1:0] byte_cnt_i,
    input  logic             sda_i,
    output logic             scl_oe_o,
    output logic             sda_oe_o,
    output logic [7:0]       data_o,
    output logic             valid_o,
    output logic             done_o,
    output logic             nack_err_o
);
    localparam logic [3:0]       ACK_BIT = 4'd8;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    typedef struct packed {
        ctl_state_e       st;
        logic [1:0]       stage;
        logic [3:0]       bitn;
        logic [7:0]       tx;
        logic [7:0]       rx;
        logic [CNT_W-1:0] remain;
        logic [7:0]       waddr;
        logic             restart;
        logic             ack;
        logic             err;
        logic [7:0]       data;
        logic             valid;
        logic             done;
        logic             nack_err;
    } ctl_t;

    ctl_t c_d, c_q;

    logic       busy;
    logic       tick;
    logic [1:0] phase;
    logic       sample;
    logic       bit_end;
    sym_e       sym;
    logic       rls;
    logic       cond_sym;

    assign busy     = (c_q.st != ST_IDLE);
    assign sample   = tick && (phase == 2'd2);
    assign bit_end  = tick && (phase == 2'd3);
    assign cond_sym = (sym == SYM_START) || (sym == SYM_STOP);

    eeprom_phase_gen #(.QUARTER_CLKS(QUARTER_CLKS)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (busy),
        .tick_o  (tick),
        .phase_o (phase)
    );

    always_comb begin
        unique case (c_q.st)
            ST_START: sym = SYM_START;
            ST_WR,
            ST_RD:    sym = SYM_BIT;
            ST_STOP:  sym = SYM_STOP;
            default:  sym = SYM_NONE;
        endcase
        if (c_q.st == ST_WR)      rls = (c_q.bitn == ACK_BIT) ? 1'b1 : c_q.tx[7];
        else if (c_q.st == ST_RD) rls = (c_q.bitn == ACK_BIT) ? (c_q.remain == ONE) : 1'b1;
        else                      rls = 1'b1;
    end

    eeprom_line_drv u_lines (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_i     (sym),
        .phase_i   (phase),
        .rls_i     (rls),
        .restart_i (c_q.restart),
        .scl_oe_o  (scl_oe_o),
        .sda_oe_o  (sda_oe_o)
    );

    always_comb begin
        c_d       = c_q;
        c_d.valid = 1'b0;
        c_d.done  = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.nack_err = 1'b0;
                    if (byte_cnt_i == '0) begin
                        c_d.done = 1'b1;
                    end else begin
                        c_d.st      = ST_START;
                        c_d.stage   = 2'd0;
                        c_d.restart = 1'b0;
                        c_d.remain  = byte_cnt_i;
                        c_d.waddr   = word_addr_i;
                        c_d.err     = 1'b0;
                    end
                end
            end
            ST_START: begin
                if (bit_end) begin
                    c_d.st   = ST_WR;
                    c_d.bitn = '0;
                    c_d.tx   = {DEV_ADDR, c_q.restart};
                end
            end
            ST_WR: begin
                if (sample && c_q.bitn == ACK_BIT) c_d.ack = !sda_i;
                if (bit_end) begin
                    if (c_q.bitn != ACK_BIT) begin
                        c_d.tx   = {c_q.tx[6:0], 1'b0};
                        c_d.bitn = c_q.bitn + 4'd1;
                    end else begin
                        c_d.bitn = '0;
                        if (!c_q.ack) begin
                            c_d.err = 1'b1;
                            c_d.st  = ST_STOP;
                        end else if (c_q.stage == 2'd0) begin
                            c_d.stage = 2'd1;
                            c_d.tx    = c_q.waddr;
                        end else if (c_q.stage == 2'd1) begin
                            c_d.stage   = 2'd2;
                            c_d.restart = 1'b1;
                            c_d.st      = ST_START;
                        end else begin
                            c_d.st = ST_RD;
                        end
                    end
                end
            end
            ST_RD: begin
                if (sample && c_q.bitn != ACK_BIT) c_d.rx = {c_q.rx[6:0], sda_i};
                if (bit_end) begin
                    if (c_q.bitn == 4'd7) begin
                        c_d.data  = c_q.rx;
                        c_d.valid = 1'b1;
                    end
                    if (c_q.bitn != ACK_BIT) begin
                        c_d.bitn = c_q.bitn + 4'd1;
                    end else begin
                        c_d.bitn   = '0;
                        c_d.remain = c_q.remain - ONE;
                        if (c_q.remain == ONE) c_d.st = ST_STOP;
                    end
                end
            end
            ST_STOP: begin
                if (bit_end) begin
                    c_d.st       = ST_IDLE;
                    c_d.done     = 1'b1;
                    c_d.nack_err = c_q.err;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign data_o     = c_q.data;
    assign valid_o    = c_q.valid;
    assign done_o     = c_q.done;
    assign nack_err_o = c_q.nack_err;
endmodule

// File: rtl/eeprom_seq_reader_chk.sv
module eeprom_seq_reader_chk (
    input logic clk,
    input logic rst_n,
    input logic busy_i,
    input logic cond_i,
    input logic scl_oe_i,
    input logic sda_oe_i,
    input logic valid_i,
    input logic done_i,
    input logic err_i
);
    // R1: an idle controller releases both lines
    p_idle_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_i && !$past(busy_i)) |-> (!scl_oe_i && !sda_oe_i));

    // R3: SDA moves while SCL is released only inside a START or STOP symbol
    p_sda_edge_scl_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((sda_oe_i != $past(sda_oe_i)) && !scl_oe_i && !$past(scl_oe_i)) |-> $past(cond_i));

    // R4: the byte strobe lasts one cycle
    p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> !valid_i);

    // R6: byte strobe and completion never coincide
    p_valid_not_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_i && done_i));

    // R7: the error flag rises only together with completion
    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && !$past(err_i)) |-> done_i);

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !done_i);
endmodule

bind eeprom_seq_reader eeprom_seq_reader_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_i   (busy),
    .cond_i   (cond_sym),
    .scl_oe_i (scl_oe_o),
    .sda_oe_i (sda_oe_o),
    .valid_i  (valid_o),
    .done_i   (done_o),
    .err_i    (nack_err_o)
);

// File: tb/test_eeprom_seq_reader.sv
`timescale 1ns/1ps
module test_eeprom_seq_reader;
    localparam int QC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] word_addr_i = '0;
    logic [7:0] byte_cnt_i = '0;
    logic       scl_oe, sda_oe;
    logic [7:0] data_o;
    logic       valid_o, done_o, nack_err_o;
    logic       sda_s = 1'b0;
    wire        scl_w = !scl_oe;
    wire        sda_w = !(sda_oe || sda_s);

    always #2 clk = !clk;

    eeprom_seq_reader #(.QUARTER_CLKS(QC), .CNT_W(8)) i_eeprom_seq_reader (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_addr_i(word_addr_i),
        .byte_cnt_i(byte_cnt_i), .sda_i(sda_w), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe),
        .data_o(data_o), .valid_o(valid_o), .done_o(done_o), .nack_err_o(nack_err_o)
    );

    int nchk = 0, nfail = 0;
    int n_start, n_stop, n_rx, n_mack, n_mnack, nack_at;
    int vcount, dcount, tviol, stops_at_done, last_err;
    logic [7:0] rx_log [4];
    logic [7:0] vdata [32];

    function automatic logic [7:0] memv(input logic [7:0] a);
        return {a[3:0], a[7:4]} ^ 8'hA5;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural EEPROM slave
    int st = 0, bc = 0;
    bit in_ack = 0, last_mack = 0, p_scl = 1, p_sda = 1;
    logic [7:0] sh = '0, ptr = '0, rd = '0;
    always @(negedge clk) begin
        bit s_scl, s_sda;
        s_scl = scl_w;
        s_sda = sda_w;
        if (s_scl && p_scl && p_sda && !s_sda) begin
            st = 1; bc = 0; in_ack = 0; sda_s = 0; n_start++;
        end else if (s_scl && p_scl && !p_sda && s_sda) begin
            st = 0; sda_s = 0; n_stop++;
        end else if (s_scl && !p_scl) begin
            if (st == 1 || st == 2) begin
                if (bc < 8) begin sh = {sh[6:0], s_sda}; bc++; end
            end else if (st == 3) begin
                if (bc < 8) bc++;
                else if (bc == 8) begin
                    last_mack = !s_sda;
                    if (!s_sda) n_mack++; else n_mnack++;
                    bc = 9;
                end
            end
        end else if (!s_scl && p_scl) begin
            if (st == 1 || st == 2) begin
                if (bc == 8 && !in_ack) begin
                    in_ack = 1;
                    if (n_rx < 4) rx_log[n_rx] = sh;
                    n_rx++;
                    sda_s = (n_rx != nack_at);
                end else if (in_ack) begin
                    in_ack = 0; bc = 0; sda_s = 0;
                    if (st == 1) begin
                        if (sh[0]) begin st = 3; rd = memv(ptr); sda_s = !rd[7]; end
                        else st = 2;
                    end else begin
                        ptr = sh; st = 0;
                    end
                end
            end else if (st == 3) begin
                if (bc < 8) sda_s = !rd[7-bc];
                else if (bc == 8) sda_s = 0;
                else if (last_mack) begin
                    ptr++; rd = memv(ptr); bc = 0; sda_s = !rd[7];
                end else begin
                    st = 0; sda_s = 0;
                end
            end
        end
        p_scl = s_scl;
        p_sda = s_sda;
    end

    // output and SCL timing monitor
    int w = 0;
    bit m_scl = 1, hi_valid = 0;
    always @(negedge clk) begin
        if (valid_o) begin
            if (vcount < 32) vdata[vcount] = data_o;
            vcount++;
        end
        if (done_o) begin
            dcount++; last_err = nack_err_o; stops_at_done = n_stop; hi_valid = 0;
        end
        if (scl_w != m_scl) begin
            if (!scl_w && hi_valid && w != 2*QC) tviol++;
            if (scl_w) begin
                if (w != 2*QC) tviol++;
                hi_valid = 1;
            end
            w = 1;
        end else begin
            w++;
        end
        m_scl = scl_w;
    end

    task automatic clr(input int sel);
        n_start = 0; n_stop = 0; n_rx = 0; n_mack = 0; n_mnack = 0; nack_at = sel;
        vcount = 0; dcount = 0; tviol = 0; stops_at_done = 0; last_err = 0;
    endtask

    task automatic kick(input logic [7:0] wa, input logic [7:0] n);
        @(negedge clk);
        word_addr_i = wa; byte_cnt_i = n; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        int k = 0;
        while (dcount == 0 && k < 20000) begin @(negedge clk); k++; end
        chk("R8 watchdog done seen", dcount, 1);
        repeat (2 * QC) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 valid", valid_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 nack_err", nack_err_o, 0);
    endtask

    task automatic t_read(input logic [7:0] wa, input int n);
        clr(0);
        kick(wa, 8'(n));
        wait_done();
        chk("R2 address bytes", n_rx, 3);
        chk("R2 write address 0xA0", rx_log[0], 8'hA0);
        chk("R2 word address", rx_log[1], wa);
        chk("R2 read address 0xA1", rx_log[2], 8'hA1);
        chk("R2 SCL phase widths", tviol, 0);
        chk("R3 START count", n_start, 2);
        chk("R3 STOP count", n_stop, 1);
        chk("R6 byte count", vcount, n);
        for (int i = 0; i < n && i < 32; i++)
            chk($sformatf("R4 byte %0d", i), vdata[i], memv(8'(wa + 8'(i))));
        chk("R5 master ACKs", n_mack, n - 1);
        chk("R5 master NACKs", n_mnack, 1);
        chk("R8 single done", dcount, 1);
        chk("R8 STOP before done", stops_at_done, 1);
        chk("R8 no error", last_err, 0);
    endtask

    task automatic t_nack(input int sel);
        clr(sel);
        kick(8'h20, 8'd4);
        wait_done();
        chk("R7 error flag", last_err, 1);
        chk("R7 no bytes", vcount, 0);
        chk("R7 bytes offered", n_rx, sel);
        chk("R7 STOP issued", n_stop, 1);
        chk("R7 START count", n_start, (sel == 3) ? 2 : 1);
        repeat (20) @(negedge clk);
        chk("R7 flag held", nack_err_o, 1);
    endtask

    task automatic t_zero();
        clr(0);
        @(negedge clk);
        word_addr_i = 8'h33; byte_cnt_i = 8'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R10 done next cycle", done_o, 1);
        chk("R10 no error", nack_err_o, 0);
        repeat (40) @(negedge clk);
        chk("R10 no START", n_start, 0);
        chk("R10 no valid", vcount, 0);
        chk("R10 SCL released", scl_oe, 0);
    endtask

    task automatic t_busy();
        int k = 0;
        clr(0);
        kick(8'h10, 8'd2);
        repeat (300) @(negedge clk);
        kick(8'h80, 8'd5);
        while (dcount == 0 && k < 20000) begin @(negedge clk); k++; end
        repeat (200) @(negedge clk);
        chk("R9 single done", dcount, 1);
        chk("R9 byte count kept", vcount, 2);
        chk("R9 START count", n_start, 2);
        chk("R9 byte 0 address kept", vdata[0], memv(8'h10));
        chk("R9 byte 1 address kept", vdata[1], memv(8'h11));
    endtask

    initial begin
        clr(0);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_read(8'h00, 3);
        t_read(8'hFE, 5);
        t_read(8'h5C, 1);
        t_nack(1);
        t_read(8'h40, 2);
        t_nack(2);
        t_nack(3);
        t_zero();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule